// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block lets an external host reach a processor's on-chip program memory (PM, 24-bit words) and data memory (DM, 16-bit words) over one 16-bit bus that carries address and data at different times. The host works with four active-high strobes: select, address-latch, read and write. None of them is related to the processor clock. Each strobe passes through a one-flop synchronizer. The block then runs one memory access per host read or write on a synchronous RAM interface.

A host session starts with a latch cycle. The top bus bit picks what the cycle loads: a 14-bit start address plus a PM/DM destination bit, or a pair of memory bank numbers. After that the host issues plain reads and writes, and the address steps forward by itself after each word. A PM word needs two host accesses: the upper 16 bits first, then the low 8 bits. The processor side can also load the start address and the bank/short-read register through two memory-mapped locations. The host has no way to read either register back. The memory and register-write interfaces are plain single-cycle strobes with no back-pressure: the RAM takes every request in the cycle it is issued, and the host must wait for the acknowledge to return high before it starts another access.

Top module: `host_mem_port`

## Requirements
- R1: After reset, `h_ack` is 1, `h_dout` is 0, `mem_req` is 0, and `cpu_ovl_q`, `pm_bank`, `dm_bank` and `short_rd` are all 0. The start address has no promised reset value.
- R2: A latch cycle loads the address when bus bit 15 is 0. Bits 13:0 become the start address and bit 14 becomes the destination (0 = PM, 1 = DM). The value takes effect when the latch strobe falls while select is still high, and it appears on `mem_addr`/`mem_dm`.
- R3: A latch cycle loads the banks when bus bit 15 is 1. Bits 3:0 become the PM bank and bits 7:4 become the DM bank. The address, the destination and `short_rd` are left unchanged. Later accesses go to the selected bank.
- R4: For a DM access, the data is on bus bits 15:0. Every read or write makes exactly one memory operation and then adds 1 to the address.
- R5: A PM word takes two host accesses. The first carries bits 23:8 and the second carries bits 7:0 in bus bits 7:0. A PM write makes one memory write of the whole 24-bit word on the second access. A PM read gets bits 7:0 back with bus bits 15:8 at zero. The address steps only after the second access.
- R6: `h_ack` goes low in the cycle after the processor clock first samples a read or write strobe, and it stays low for exactly three cycles. The memory request is a single cycle and falls in the second of those three cycles.
- R7: A processor write to DM location 0x3FE0 loads the start address from data bits 13:0 and the destination from bit 14. It also restarts PM word pairing at the upper half.
- R8: A processor write to location 0x3FE7 loads the PM bank from bits 3:0, the DM bank from bits 7:4 and `short_rd` from bit 14. `cpu_ovl_q` returns those fields in the same positions with every other bit 0. Writes to any other location change nothing.
- R9: If a host address latch and a processor write to 0x3FE0 take effect in the same cycle, the host value is kept.
- R10: Read, write and latch strobes have no effect while select is low. `h_ack` stays high, no memory request is made, and the address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| h_sel | input | 1 | Host select, asynchronous |
| h_alat | input | 1 | Host address/bank latch strobe, asynchronous |
| h_rd | input | 1 | Host read strobe, asynchronous |
| h_wr | input | 1 | Host write strobe, asynchronous |
| h_din | input | 16 | Host bus driven by the host (address, bank or write data) |
| h_dout | output | 16 | Host bus read data, held until the next read |
| h_ack | output | 1 | Acknowledge; low while an access is in progress |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_addr | input | 14 | Processor DM write address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ovl_q | output | 16 | Bank/short-read register as the processor reads it |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Memory request is a write |
| mem_dm | output | 1 | Destination: 1 = DM, 0 = PM |
| mem_addr | output | 14 | Current memory address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid the cycle after a read request |
| pm_bank | output | 4 | PM bank number |
| dm_bank | output | 4 | DM bank number |
| short_rd | output | 1 | Short-read-only mode enable |

## Verification
A host latch commit and a processor write to the start-address location can land in the same processor cycle. Both write the same address and destination flops. The bench drops the latch strobe on one falling clock edge and raises the processor write strobe on the next falling edge. Both are then sampled at the rising edge where the synchronized latch fall commits. The bench then expects `mem_addr` and `mem_dm` to show the host's value and not the processor's.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {XF_IDLE, XF_ACCESS, XF_FINISH} xf_state_t;
  localparam int STB_SEL  = 0;
  localparam int STB_ALAT = 1;
  localparam int STB_RD   = 2;
  localparam int STB_WR   = 3;
  localparam int STB_N    = 4;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q1, q2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1 <= 1'b0;
        q2 <= 1'b0;
      end else begin
        q1 <= async_i[g];
        q2 <= q1;
      end
    end
    assign lvl_o[g]  = q1;
    assign rise_o[g] = q1 & ~q2;
    assign fall_o[g] = ~q1 & q2;
  end
endmodule

// File: rtl/hmp_regs.sv
module hmp_regs #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter int BANK_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3FE0,
  parameter logic [ADDR_W-1:0] OVL_ADDR  = 'h3FE7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              sel_i,
  input  logic              alat_lvl_i,
  input  logic              commit_i,
  input  logic              step_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [BUS_W-1:0]  cpu_wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_dm_o,
  output logic [BANK_W-1:0] pm_bank_o,
  output logic [BANK_W-1:0] dm_bank_o,
  output logic              short_rd_o,
  output logic [BUS_W-1:0]  ovl_q_o,
  output logic              restart_o
);
  localparam int DEST_BIT  = ADDR_W;
  localparam int MODE_BIT  = BUS_W - 1;
  localparam int SHORT_BIT = BUS_W - 2;

  logic [BUS_W-1:0] hold;
  logic host_addr, host_ovl, cpu_ctrl, cpu_ovl;
  logic unused_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold <= '0;
    else if (sel_i & alat_lvl_i) hold <= bus_i;
  end

  assign host_addr = commit_i & ~hold[MODE_BIT];
  assign host_ovl  = commit_i &  hold[MODE_BIT];
  assign cpu_ctrl  = cpu_we_i & (cpu_addr_i == CTRL_ADDR);
  assign cpu_ovl   = cpu_we_i & (cpu_addr_i == OVL_ADDR);
  assign restart_o = host_addr | cpu_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      is_dm_o <= 1'b0;
    end else if (host_addr) begin
      addr_o  <= hold[ADDR_W-1:0];
      is_dm_o <= hold[DEST_BIT];
    end else if (cpu_ctrl) begin
      addr_o  <= cpu_wdata_i[ADDR_W-1:0];
      is_dm_o <= cpu_wdata_i[DEST_BIT];
    end else if (step_i) begin
      addr_o  <= addr_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_bank_o  <= '0;
      dm_bank_o  <= '0;
      short_rd_o <= 1'b0;
    end else if (host_ovl) begin
      pm_bank_o <= hold[BANK_W-1:0];
      dm_bank_o <= hold[2*BANK_W-1:BANK_W];
    end else if (cpu_ovl) begin
      pm_bank_o  <= cpu_wdata_i[BANK_W-1:0];
      dm_bank_o  <= cpu_wdata_i[2*BANK_W-1:BANK_W];
      short_rd_o <= cpu_wdata_i[SHORT_BIT];
    end
  end

  always_comb begin
    ovl_q_o = '0;
    ovl_q_o[BANK_W-1:0]        = pm_bank_o;
    ovl_q_o[2*BANK_W-1:BANK_W] = dm_bank_o;
    ovl_q_o[SHORT_BIT]         = short_rd_o;
  end

  assign unused_wbit = cpu_wdata_i[MODE_BIT];
endmodule

// File: rtl/hmp_xfer.sv
module hmp_xfer
  import hmp_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int PM_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go_i,
  input  logic             wr_go_i,
  input  logic             restart_i,
  input  logic             is_dm_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [PM_W-1:0]  mem_rdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PM_W-1:0]  mem_wdata_o,
  output logic [BUS_W-1:0] dout_o,
  output logic             busy_o,
  output logic             step_o
);
  localparam int LO_W = PM_W - BUS_W;

  xf_state_t        st;
  logic             op_wr;
  logic             phase;
  logic [BUS_W-1:0] wdat;
  logic [BUS_W-1:0] pm_hi;
  logic [LO_W-1:0]  lo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= XF_IDLE;
      op_wr   <= 1'b0;
      phase   <= 1'b0;
      wdat    <= '0;
      pm_hi   <= '0;
      lo_byte <= '0;
      dout_o  <= '0;
    end else begin
      case (st)
        XF_IDLE: begin
          if (rd_go_i | wr_go_i) begin
            st    <= XF_ACCESS;
            op_wr <= wr_go_i;
            wdat  <= bus_i;
          end
        end
        XF_ACCESS: begin
          st <= XF_FINISH;
          if (op_wr & ~is_dm_i & ~phase) pm_hi <= wdat;
        end
        XF_FINISH: begin
          st <= XF_IDLE;
          if (!op_wr) begin
            if (is_dm_i) begin
              dout_o <= mem_rdata_i[BUS_W-1:0];
            end else if (!phase) begin
              dout_o  <= mem_rdata_i[PM_W-1:LO_W];
              lo_byte <= mem_rdata_i[LO_W-1:0];
            end else begin
              dout_o <= {{(BUS_W-LO_W){1'b0}}, lo_byte};
            end
          end
          phase <= is_dm_i ? 1'b0 : ~phase;
        end
        default: st <= XF_IDLE;
      endcase
      if (restart_i) phase <= 1'b0;
    end
  end

  assign mem_req_o   = (st == XF_ACCESS) & (is_dm_i | (op_wr ? phase : ~phase));
  assign mem_we_o    = mem_req_o & op_wr;
  assign mem_wdata_o = is_dm_i ? {{LO_W{1'b0}}, wdat} : {pm_hi, wdat[LO_W-1:0]};
  assign step_o      = (st == XF_FINISH) & (is_dm_i | phase);
  assign busy_o      = (st != XF_IDLE);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter int PM_W   = 24,
  parameter int BANK_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3FE0,
  parameter logic [ADDR_W-1:0] OVL_ADDR  = 'h3FE7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_alat,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [BUS_W-1:0]  h_din,
  output logic [BUS_W-1:0]  h_dout,
  output logic              h_ack,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  output logic [BUS_W-1:0]  cpu_ovl_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PM_W-1:0]   mem_wdata,
  input  logic [PM_W-1:0]   mem_rdata,
  output logic [BANK_W-1:0] pm_bank,
  output logic [BANK_W-1:0] dm_bank,
  output logic              short_rd
);
  logic [STB_N-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
  logic [BUS_W-1:0] bus_s1;
  logic sel_lvl, rd_go, wr_go, commit, busy, step, restart;
  logic unused_sync;

  assign stb_raw = {h_wr, h_rd, h_alat, h_sel};

  hmp_sync #(.N(STB_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(stb_raw),
    .lvl_o(stb_lvl), .rise_o(stb_rise), .fall_o(stb_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_s1 <= '0;
    else        bus_s1 <= h_din;
  end

  assign sel_lvl = stb_lvl[STB_SEL];
  assign rd_go   = stb_rise[STB_RD] & sel_lvl & ~busy;
  assign wr_go   = stb_rise[STB_WR] & sel_lvl & ~busy;
  assign commit  = stb_fall[STB_ALAT] & sel_lvl;
  assign h_ack   = ~(busy | rd_go | wr_go);

  hmp_regs #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BANK_W(BANK_W),
    .CTRL_ADDR(CTRL_ADDR), .OVL_ADDR(OVL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_s1), .sel_i(sel_lvl),
    .alat_lvl_i(stb_lvl[STB_ALAT]), .commit_i(commit), .step_i(step),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .addr_o(mem_addr), .is_dm_o(mem_dm), .pm_bank_o(pm_bank),
    .dm_bank_o(dm_bank), .short_rd_o(short_rd), .ovl_q_o(cpu_ovl_q),
    .restart_o(restart)
  );

  hmp_xfer #(.BUS_W(BUS_W), .PM_W(PM_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .rd_go_i(rd_go), .wr_go_i(wr_go),
    .restart_i(restart), .is_dm_i(mem_dm), .bus_i(bus_s1),
    .mem_rdata_i(mem_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .dout_o(h_dout), .busy_o(busy), .step_o(step)
  );

  assign unused_sync = ^{stb_lvl, stb_rise, stb_fall};
endmodule

// File: rtl/host_mem_port_chk.sv
module host_mem_port_chk #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter logic [ADDR_W-1:0] OVL_ADDR = 'h3FE7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_ack,
  input logic              mem_req,
  input logic              sel_lvl,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BUS_W-1:0]  cpu_wdata,
  input logic              short_rd
);
  // R6
  req_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !h_ack);

  // R6
  ack_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_ack) |=> !h_ack);

  // R6
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8
  short_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_we) && ($past(cpu_addr) == OVL_ADDR)) |-> (short_rd == $past(cpu_wdata[BUS_W-2])));

  // R10
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_ack) |-> sel_lvl);
endmodule

bind host_mem_port host_mem_port_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .OVL_ADDR(OVL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_ack(h_ack), .mem_req(mem_req),
  .sel_lvl(sel_lvl), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .short_rd(short_rd)
);

// File: tb/host_mem_port_bench.sv
`timescale 1ns/1ps
module host_mem_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 0, h_alat = 0, h_rd = 0, h_wr = 0;
  logic [15:0] h_din = '0;
  logic [15:0] h_dout;
  logic        h_ack;
  logic        cpu_we = 0;
  logic [13:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_ovl_q;
  logic        mem_req, mem_we, mem_dm, short_rd;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;
  logic [3:0]  pm_bank, dm_bank;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        smp_ev;
  logic [23:0] ram [int];

  always #10 clk = ~clk;

  host_mem_port u_host_mem_port (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_alat(h_alat), .h_rd(h_rd),
    .h_wr(h_wr), .h_din(h_din), .h_dout(h_dout), .h_ack(h_ack),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ovl_q(cpu_ovl_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_dm(mem_dm), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pm_bank(pm_bank), .dm_bank(dm_bank),
    .short_rd(short_rd)
  );

  function automatic int ram_key(input logic dm, input logic [3:0] bank, input logic [13:0] a);
    return int'({dm, bank, a});
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[ram_key(mem_dm, mem_dm ? dm_bank : pm_bank, mem_addr)] = mem_wdata;
      else if (ram.exists(ram_key(mem_dm, mem_dm ? dm_bank : pm_bank, mem_addr)))
        mem_rdata <= ram[ram_key(mem_dm, mem_dm ? dm_bank : pm_bank, mem_addr)];
      else mem_rdata <= '0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic host_latch(input logic [15:0] v);
    @(negedge clk); h_sel = 1; h_alat = 1; h_din = v;
    repeat (3) @(negedge clk); h_alat = 0;
    repeat (3) @(negedge clk); h_sel = 0;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d);
    @(negedge clk); h_sel = 1; h_wr = 1; h_din = d;
    repeat (6) @(negedge clk); h_wr = 0;
    repeat (3) @(negedge clk); h_sel = 0;
    @(negedge clk);
  endtask

  // driver: pushes the expected word, then performs the read
  task automatic host_read(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); h_sel = 1; h_rd = 1;
    repeat (6) @(negedge clk);
    -> smp_ev;
    h_rd = 0;
    repeat (3) @(negedge clk); h_sel = 0;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
    @(negedge clk);
  endtask

  // monitor: pops and compares as read results appear
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4: unexpected read result %h", h_dout);
      end else begin
        string t;
        logic [15:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, {16'h0, h_dout}, {16'h0, e});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [13:0] a_snap;
    int lo_cnt, req_at;
    logic ack_bad, req_bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ack", h_ack, 1);
    check("R1 dout", h_dout, 0);
    check("R1 ovl", cpu_ovl_q, 0);
    check("R1 req", mem_req, 0);
    check("R1 short", short_rd, 0);

    // R2 / R4 DM block write then readback
    host_latch(16'h4100);
    check("R2 addr", mem_addr, 14'h100);
    check("R2 dest", mem_dm, 1);
    host_write(16'h1111); host_write(16'h2222); host_write(16'h3333);
    check("R4 addr step", mem_addr, 14'h103);
    check("R4 stored", ram[ram_key(1'b1, 4'd0, 14'h101)], 24'h002222);
    host_latch(16'h4100);
    host_read(16'h1111, "R4 rd0"); host_read(16'h2222, "R4 rd1"); host_read(16'h3333, "R4 rd2");

    // R5 PM packing
    host_latch(16'h0020);
    check("R2 pm dest", mem_dm, 0);
    host_write(16'hABCD);
    check("R5 no step on half", mem_addr, 14'h020);
    host_write(16'h00EF);
    check("R5 step after pair", mem_addr, 14'h021);
    host_write(16'h1234); host_write(16'h0056);
    check("R5 word0", ram[ram_key(1'b0, 4'd0, 14'h020)], 24'hABCDEF);
    check("R5 word1", ram[ram_key(1'b0, 4'd0, 14'h021)], 24'h123456);
    host_latch(16'h0020);
    host_read(16'hABCD, "R5 hi0"); host_read(16'h00EF, "R5 lo0");
    host_read(16'h1234, "R5 hi1"); host_read(16'h0056, "R5 lo1");
    check("R5 addr", mem_addr, 14'h022);

    // R3 bank latch
    a_snap = mem_addr;
    host_latch(16'h8053);
    check("R3 pm bank", pm_bank, 4'd3);
    check("R3 dm bank", dm_bank, 4'd5);
    check("R3 addr kept", mem_addr, a_snap);
    check("R3 ovl view", cpu_ovl_q, 16'h0053);
    host_latch(16'h4100);
    host_write(16'h7777);
    host_latch(16'h4100);
    host_read(16'h7777, "R3 bank5");
    host_latch(16'h8000);
    host_latch(16'h4100);
    host_read(16'h1111, "R3 bank0");

    // R6 latency
    lo_cnt = 0; req_at = 0;
    @(negedge clk); h_sel = 1; h_rd = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (!h_ack) lo_cnt++;
      if (mem_req) req_at = i;
    end
    check("R6 ack low cycles", lo_cnt, 3);
    check("R6 req cycle", req_at, 2);
    h_rd = 0; repeat (3) @(negedge clk); h_sel = 0; @(negedge clk);

    // R10 strobes without select
    a_snap = mem_addr; ack_bad = 0; req_bad = 0;
    @(negedge clk); h_rd = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!h_ack) ack_bad = 1;
      if (mem_req) req_bad = 1;
    end
    h_rd = 0; h_wr = 1; h_din = 16'hBEEF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!h_ack) ack_bad = 1;
      if (mem_req) req_bad = 1;
    end
    h_wr = 0; h_alat = 1; h_din = 16'h0055;
    repeat (3) @(negedge clk); h_alat = 0; repeat (3) @(negedge clk);
    check("R10 ack", ack_bad, 0);
    check("R10 req", req_bad, 0);
    check("R10 addr", mem_addr, a_snap);

    // R7 / R8 processor registers
    cpu_write(14'h3FE0, 16'h4200);
    check("R7 addr", mem_addr, 14'h200);
    check("R7 dest", mem_dm, 1);
    cpu_write(14'h3FE7, 16'h40A2);
    check("R8 short", short_rd, 1);
    check("R8 banks", {pm_bank, dm_bank}, 8'h2A);
    check("R8 view", cpu_ovl_q, 16'h40A2);
    cpu_write(14'h3FE7, 16'hFFFF);
    check("R8 unused zero", cpu_ovl_q, 16'h40FF);
    cpu_write(14'h3FE1, 16'h0000);
    check("R8 other addr", cpu_ovl_q, 16'h40FF);
    check("R7 other addr", mem_addr, 14'h200);

    // R9 same-cycle host latch and processor address write
    @(negedge clk); h_sel = 1; h_alat = 1; h_din = 16'h0300;
    repeat (3) @(negedge clk); h_alat = 0;
    @(negedge clk); cpu_we = 1; cpu_addr = 14'h3FE0; cpu_wdata = 16'h4400;
    @(negedge clk); cpu_we = 0;
    repeat (2) @(negedge clk); h_sel = 0; @(negedge clk);
    check("R9 addr", mem_addr, 14'h300);
    check("R9 dest", mem_dm, 0);

    repeat (4) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    report();
  end
endmodule